// File: doc/BRIEF.md
# BCD Alarm Field Comparator

This block holds two programmable alarm words, one for the time of day and one for the calendar, and compares them against the running BCD time and calendar words of a real-time clock. Each comparable field (seconds, minutes, hours, month, day of month) has its own enable bit inside the alarm word. A field whose enable is clear does not constrain the match. The year and century are never compared, and the calendar alarm word has no storage for them.

The comparison is made only in the cycle where the one-second tick is high. A hit gives a single-cycle event pulse one clock later and sets a sticky alarm flag. Software clears the flag by writing a one to bit 1 of the status-clear port. Each alarm word reports whether any of its enabled fields holds a value that is not valid BCD or is out of range. An alarm word flagged this way never fires. Interrupt masking is left to the interrupt controller downstream.

Top module: `rtc_alarm_matcher`

## Requirements
- R1: After reset the event pulse and the alarm flag are 0, both alarm words read back as zero with every enable clear, and both invalid indications are 0.
- R2: Time alarm word layout: seconds in bits 6:0 with enable bit 7, minutes in bits 14:8 with enable bit 15, hours in bits 21:16 with enable bit 23. Read-back returns exactly these bits and 0 elsewhere. Hours are compared on bits 21:16 only, so bit 22 of the current time has no effect.
- R3: Calendar alarm word layout: month in bits 20:16 with enable bit 23, day of month in bits 29:24 with enable bit 31. There is no year or century field, and all other bits read back as 0.
- R4: A field whose enable bit is 0 counts as matching. With all five enables at 0, no alarm ever fires.
- R5: The comparison happens only in a cycle where `sec_tick` is 1. A hit drives `alarm_pulse` high for exactly the following cycle. A matching time with `sec_tick` at 0 gives no pulse.
- R6: `alarm_pulse` sets `alarm_flag` on the same clock edge, and the flag stays set until it is cleared.
- R7: A clear write with bit 1 at 1 clears the flag. A clear write with bit 1 at 0 has no effect. If a hit and a clear land on the same edge, the flag ends up set.
- R8: `tim_invalid` is 1 when an enabled field holds a bad value: seconds or minutes not BCD 00 to 59, or hours not BCD 00 to 23. A value is not BCD when either nibble is above 9. Disabled fields are not checked.
- R9: `cal_invalid` is 1 when an enabled field holds a bad value: month not BCD 01 to 12, or day of month not BCD 01 to 31. Disabled fields are not checked.
- R10: While either invalid indication is 1, no alarm fires, even if every field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| cur_time | input | 32 | Running BCD time word |
| cur_cal | input | 32 | Running BCD calendar word |
| tim_wr | input | 1 | Write strobe for the time alarm word |
| cal_wr | input | 1 | Write strobe for the calendar alarm word |
| wr_data | input | 32 | Write data for the alarm words |
| clr_wr | input | 1 | Status-clear write strobe |
| clr_data | input | 32 | Status-clear data; bit 1 clears the alarm flag |
| alarm_pulse | output | 1 | Single-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm status |
| tim_alarm_rd | output | 32 | Time alarm word read-back |
| cal_alarm_rd | output | 32 | Calendar alarm word read-back |
| tim_invalid | output | 1 | Time alarm word holds an invalid enabled field |
| cal_invalid | output | 1 | Calendar alarm word holds an invalid enabled field |

## Verification
The bench runs every combination of the five enables against every pattern of matching and mismatching fields. A design that treats a disabled field as a mismatch, or fires with no enables set, shows up there. The validity flags are swept over every code each field can hold, including codes with a nibble above 9 and the zero month and day. An off-by-one range limit or a missing digit check would flip the flag at those codes. Further checks send a matching time without a tick and with bit 22 set in the current time, and send a clear at the same edge as a hit. A block that compares freely, reads the AM/PM bit, or lets the clear win would show a pulse or flag that differs from the expected value.

// File: rtl/rtc_alarm_matcher.sv
`timescale 1ns/1ps
module rtc_alarm_matcher (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic [31:0] cur_time,
  input  logic [31:0] cur_cal,
  input  logic        tim_wr,
  input  logic        cal_wr,
  input  logic [31:0] wr_data,
  input  logic        clr_wr,
  input  logic [31:0] clr_data,
  output logic        alarm_pulse,
  output logic        alarm_flag,
  output logic [31:0] tim_alarm_rd,
  output logic [31:0] cal_alarm_rd,
  output logic        tim_invalid,
  output logic        cal_invalid
);
  localparam logic [31:0] TIM_KEEP = 32'h00BF_FFFF;
  localparam logic [31:0] CAL_KEEP = 32'hBF9F_0000;
  localparam int CLR_BIT = 1;

  function automatic logic bcd_in(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  logic [31:0] tq, cq;
  logic sec_en, min_en, hr_en, mon_en, day_en;
  logic sec_hit, min_hit, hr_hit, mon_hit, day_hit;
  logic any_en, fire;

  assign sec_en = tq[7];
  assign min_en = tq[15];
  assign hr_en  = tq[23];
  assign mon_en = cq[23];
  assign day_en = cq[31];

  assign tim_invalid = (sec_en && !bcd_in({1'b0, tq[6:0]},   8'h00, 8'h59))
                    || (min_en && !bcd_in({1'b0, tq[14:8]},  8'h00, 8'h59))
                    || (hr_en  && !bcd_in({2'b0, tq[21:16]}, 8'h00, 8'h23));
  assign cal_invalid = (mon_en && !bcd_in({3'b0, cq[20:16]}, 8'h01, 8'h12))
                    || (day_en && !bcd_in({2'b0, cq[29:24]}, 8'h01, 8'h31));

  assign sec_hit = !sec_en || (cur_time[6:0]   == tq[6:0]);
  assign min_hit = !min_en || (cur_time[14:8]  == tq[14:8]);
  assign hr_hit  = !hr_en  || (cur_time[21:16] == tq[21:16]);
  assign mon_hit = !mon_en || (cur_cal[20:16]  == cq[20:16]);
  assign day_hit = !day_en || (cur_cal[29:24]  == cq[29:24]);

  assign any_en = sec_en | min_en | hr_en | mon_en | day_en;
  assign fire = sec_tick && any_en && !tim_invalid && !cal_invalid
             && sec_hit && min_hit && hr_hit && mon_hit && day_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tq <= '0;
      cq <= '0;
      alarm_pulse <= 1'b0;
      alarm_flag <= 1'b0;
    end else begin
      if (tim_wr) tq <= wr_data & TIM_KEEP;
      if (cal_wr) cq <= wr_data & CAL_KEEP;
      alarm_pulse <= fire;
      if (fire) alarm_flag <= 1'b1;
      else if (clr_wr && clr_data[CLR_BIT]) alarm_flag <= 1'b0;
    end
  end

  assign tim_alarm_rd = tq;
  assign cal_alarm_rd = cq;
endmodule

module rtc_alarm_matcher_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_tick,
  input logic        clr_wr,
  input logic [31:0] clr_data,
  input logic        alarm_pulse,
  input logic        alarm_flag,
  input logic [31:0] tim_alarm_rd,
  input logic [31:0] cal_alarm_rd,
  input logic        tim_invalid,
  input logic        cal_invalid
);
  assert_pulse_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(sec_tick));
  assert_flag_follows_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> alarm_flag);
  assert_flag_rise_needs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> alarm_pulse);
  assert_clear_drops_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_wr && clr_data[1]) && !alarm_pulse) |-> !alarm_flag);
  assert_no_fire_when_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(!tim_invalid && !cal_invalid));
  assert_no_fire_without_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(tim_alarm_rd[7] | tim_alarm_rd[15] | tim_alarm_rd[23]
                          | cal_alarm_rd[23] | cal_alarm_rd[31]));
endmodule

bind rtc_alarm_matcher rtc_alarm_matcher_chk i_chk (.*);

// File: tb/test_rtc_alarm_matcher.sv
`timescale 1ns/1ps
module test_rtc_alarm_matcher;
  logic clk = 0, rst_n = 0, sec_tick = 0, tim_wr = 0, cal_wr = 0, clr_wr = 0;
  logic [31:0] cur_time = 0, cur_cal = 0, wr_data = 0, clr_data = 0;
  logic alarm_pulse, alarm_flag, tim_invalid, cal_invalid;
  logic [31:0] tim_alarm_rd, cal_alarm_rd;
  int total = 0, bad = 0;

  rtc_alarm_matcher i_rtc_alarm_matcher (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_tim(input logic [31:0] d);
    @(negedge clk); tim_wr = 1; wr_data = d;
    @(negedge clk); tim_wr = 0;
  endtask

  task automatic wr_cal(input logic [31:0] d);
    @(negedge clk); cal_wr = 1; wr_data = d;
    @(negedge clk); cal_wr = 0;
  endtask

  task automatic clear(input logic [31:0] d);
    @(negedge clk); clr_wr = 1; clr_data = d;
    @(negedge clk); clr_wr = 0; clr_data = 0;
  endtask

  // One tick with the given current words; returns pulse seen and whether it stayed one cycle
  task automatic tick(input logic [31:0] t, input logic [31:0] c, input logic tk,
                      output logic p, output logic p2);
    @(negedge clk); cur_time = t; cur_cal = c; sec_tick = tk;
    @(negedge clk); sec_tick = 0; p = alarm_pulse;
    @(negedge clk); p2 = alarm_pulse;
  endtask

  function automatic logic bcd_ok(input int v, input int lo, input int hi);
    int n;
    n = (v / 16) * 10 + (v % 16);
    return (v % 16) < 10 && (v / 16) < 10 && n >= lo && n <= hi;
  endfunction

  initial begin
    logic p, p2;
    logic [31:0] t, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pulse", alarm_pulse, 0);
    chk("R1 flag", alarm_flag, 0);
    chk("R1 tim word", tim_alarm_rd, 0);
    chk("R1 cal word", cal_alarm_rd, 0);
    chk("R1 invalid", {tim_invalid, cal_invalid}, 0);

    wr_tim(32'hFFFF_FFFF);
    chk("R2 readback", tim_alarm_rd, 32'h00BF_FFFF);
    wr_cal(32'hFFFF_FFFF);
    chk("R3 readback no year", cal_alarm_rd, 32'hBF9F_0000);

    // R4 sweep of enables against mismatch patterns; alarm 12:45:30, month 07, day 19
    for (int en = 0; en < 32; en++) begin
      wr_tim({8'h00, en[2], 1'b0, 6'h12, en[1], 7'h45, en[0], 7'h30});
      wr_cal({en[4], 1'b0, 6'h19, en[3], 2'b0, 5'h07, 16'h0000});
      for (int mis = 0; mis < 32; mis++) begin
        logic expf;
        t = {9'h000, 1'b1, mis[2] ? 6'h13 : 6'h12, 1'b0, mis[1] ? 7'h46 : 7'h45,
             1'b0, mis[0] ? 7'h31 : 7'h30};
        c = {2'b00, mis[4] ? 6'h20 : 6'h19, 3'b101, mis[3] ? 5'h08 : 5'h07, 16'h9920};
        expf = (en != 0) && ((en & mis) == 0);
        clear(32'h2);
        tick(t, c, 1'b1, p, p2);
        chk($sformatf("R4 en=%0d mis=%0d pulse", en, mis), p, expf);
        chk("R6 flag set", alarm_flag, expf);
        chk("R5 single cycle", p2, 0);
      end
    end

    // R5 no tick, no compare (alarm still fully enabled and matching)
    clear(32'h2);
    tick(t & 32'h0, 32'h0, 1'b0, p, p2);
    t = {9'h000, 1'b1, 6'h12, 1'b0, 7'h45, 1'b0, 7'h30};
    c = {2'b00, 6'h19, 3'b000, 5'h07, 16'h0000};
    tick(t, c, 1'b0, p, p2);
    chk("R5 no tick no pulse", p, 0);
    chk("R5 no tick flag", alarm_flag, 0);
    tick(t, c, 1'b1, p, p2);
    chk("R2 hour ignores bit22 pulse", p, 1);

    // R7 clear behaviour
    clear(32'hFFFF_FFFD);
    chk("R7 clear bit1=0 ignored", alarm_flag, 1);
    repeat (3) @(negedge clk);
    chk("R6 flag sticky", alarm_flag, 1);
    clear(32'h2);
    chk("R7 clear bit1", alarm_flag, 0);
    @(negedge clk); cur_time = t; cur_cal = c; sec_tick = 1; clr_wr = 1; clr_data = 32'h2;
    @(negedge clk); sec_tick = 0; clr_wr = 0; clr_data = 0;
    chk("R7 set wins", alarm_flag, 1);

    // R8 validity sweeps
    for (int v = 0; v < 128; v++) begin
      wr_tim({24'h0, 1'b1, v[6:0]});
      chk($sformatf("R8 sec %0h", v), tim_invalid, !bcd_ok(v, 0, 59));
      wr_tim({16'h0, 1'b1, v[6:0], 8'h0});
      chk($sformatf("R8 min %0h", v), tim_invalid, !bcd_ok(v, 0, 59));
    end
    for (int v = 0; v < 64; v++) begin
      wr_tim({8'h00, 1'b1, 1'b0, v[5:0], 16'h0});
      chk($sformatf("R8 hour %0h", v), tim_invalid, !bcd_ok(v, 0, 23));
    end
    wr_tim(32'h0000_007F);
    chk("R8 disabled field unchecked", tim_invalid, 0);
    for (int v = 0; v < 32; v++) begin
      wr_cal({8'h00, 1'b1, 2'b0, v[4:0], 16'h0});
      chk($sformatf("R9 month %0h", v), cal_invalid, !bcd_ok(v, 1, 12));
    end
    for (int v = 0; v < 64; v++) begin
      wr_cal({1'b1, 1'b0, v[5:0], 24'h0});
      chk($sformatf("R9 date %0h", v), cal_invalid, !bcd_ok(v, 1, 31));
    end
    wr_cal(32'h3F1F_0000);
    chk("R9 disabled field unchecked", cal_invalid, 0);

    // R10 invalid word never fires
    clear(32'h2);
    wr_tim(32'h0000_00DA);
    tick(32'h0000_005A, 32'h0, 1'b1, p, p2);
    chk("R10 invalid time no pulse", p, 0);
    wr_tim(32'h0000_00A5);
    wr_cal(32'h0080_0000);
    tick(32'h0000_0025, 32'h0, 1'b1, p, p2);
    chk("R10 invalid cal no pulse", p, 0);
    wr_cal(32'h0000_0000);
    tick(32'h0000_0025, 32'h0, 1'b1, p, p2);
    chk("R10 valid again fires", p, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule